// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit ROM

This block is a one-bit-wide read-only store that plays a stored configuration bitstream out serially, one bit per clock. A load device clocks it. While the chip-enable input and the output-enable side of a combined reset/output-enable input are both active, each rising edge moves an internal bit address forward and the next stored bit is presented on the data output. The data output is qualified by a drive-enable output, which stands in for a tri-state pin. A system that shares one data wire resolves that wire from the drive enables.

Asserting the reset/output-enable input clears the address to zero, clears the read-out-complete state and releases the data line. A parameter sets the polarity of this input. When the last stored bit has been consumed, the device stops, releases the data line and pulls its active-low cascade output low. That output feeds the chip enable of a following device, so a chain of devices delivers one long concatenated stream. The capacity comes from a selector over four standard sizes, or from an explicit override. The contents come from a parameter word that repeats every 64 bits. A synchronous single-bit write port, meant for test only, can alter them.

Top module: `scrom_serial`

## Requirements
- R1: While the reset/output-enable input is at its reset level, data_en is 0 and ceo_n is 1, and each clock edge returns the bit address to zero. After release, data_out shows stored bit 0 before any further edge.
- R2: With ce_n low and output enable active, data_out carries stored bit k after k rising edges since the address was last cleared, with data_en at 1. Stored bit i equals bit (i mod 64) of the init word, unless it has been written.
- R3: While ce_n is high, data_en is 0 and edges do not move the address. When ce_n goes low again, data_out resumes at the same bit.
- R4: After DEPTH advancing edges, where the last one consumes bit DEPTH-1, data_en stays at 0 and further edges change nothing until a reset.
- R5: ceo_n is 0 exactly when ce_n is low, output enable is active and the device has been read past its last bit. After read-out it follows ce_n for as long as output enable stays active.
- R6: Taking the reset/output-enable input to its reset level after read-out forces ceo_n to 1 at once, and it stays 1 until the next complete read-out. The next read-out starts at bit 0.
- R7: Parameter RST_POL chooses the reset level of rst_oe. With POL_RST_HIGH a 1 resets and a 0 enables. With POL_RST_LOW a 0 resets and a 1 enables.
- R8: A write with wr_en at 1 on a rising edge stores wr_bit at wr_addr. A later read-out returns the new value at that position.
- R9: Two devices, where the first device's ceo_n drives the second device's ce_n and both share clk and rst_oe, deliver the first device's bits and then the second device's bits with no gap. At no sample do both assert data_en.
- R10: Asserting rst_n low asynchronously clears the read-out-complete state and the address, and restores the contents to the init word. ceo_n goes to 1 and data_out to init bit 0 without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; rising edges advance the address |
| rst_n | input | 1 | Asynchronous active-low system reset, released through a two-stage synchronizer |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset / output-enable input, polarity set by RST_POL |
| wr_en | input | 1 | Test write strobe |
| wr_addr | input | AW | Test write bit address |
| wr_bit | input | 1 | Test write data |
| data_out | output | 1 | Serial data bit, registered |
| data_en | output | 1 | Drive enable for data_out (0 = high impedance) |
| ceo_n | output | 1 | Active-low cascade enable for the next device |

## Verification
The assertions check the address counter on every cycle. It clears on a reset, holds while disabled, steps by exactly one when enabled, and holds once the completion flag is set, which can only rise from the last address. Each test write is also checked to land in the addressed storage cell. Only the bench scenarios can show the stream contents bit by bit. The same holds for the cascade hand-off between two chained devices without gap or contention, for ceo_n following ce_n after read-out, for the alternative reset polarity and for the asynchronous restore of contents on system reset.

// File: rtl/scrom_pkg.sv
package scrom_pkg;

  typedef enum logic {
    POL_RST_LOW  = 1'b0,
    POL_RST_HIGH = 1'b1
  } rst_pol_e;

  localparam int unsigned INIT_PERIOD = 64;

  function automatic int unsigned std_capacity(input int sel);
    case (sel)
      0:       return 36288;
      1:       return 65536;
      2:       return 131072;
      default: return 262144;
    endcase
  endfunction

  function automatic int unsigned pick_depth(input int sel, input int ovr);
    return (ovr > 0) ? ovr : std_capacity(sel);
  endfunction

endpackage

// File: rtl/scrom_addr_ctr.sv
module scrom_addr_ctr #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv_req,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_d,
  output logic          done_q
);

  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  logic done_d;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (clr) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (adv_req && !done_q) begin
      if (addr_q == TC) begin
        done_d = 1'b1;
      end else begin
        addr_d = addr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  // R1: reset level clears address and completion
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr_q == '0) && !done_q);

  // R3: no enable, no movement
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_req && !clr) |=> $stable(addr_q) && $stable(done_q));

  // R2: one step per enabled edge below the last address
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_req && !clr && !done_q && addr_q != TC) |=> addr_q == $past(addr_q) + AW'(1));

  // R4: completion is sticky and freezes the address
  a_r4_sticky_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q && $stable(addr_q));

  // R4: completion rises only from the last address
  a_r4_tc_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(addr_q) == TC);

endmodule

// File: rtl/scrom_store.sv
module scrom_store #(
  parameter int          DEPTH     = 64,
  parameter int          AW        = 6,
  parameter logic [63:0] INIT_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          data_q
);

  logic [DEPTH-1:0] mem_q;
  logic             rd_bit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= INIT_WORD[i % scrom_pkg::INIT_PERIOD];
      end else if (wr_en && (wr_addr == AW'(i))) begin
        cell_q <= wr_bit;
      end
    end
    assign mem_q[i] = cell_q;
  end

  // forward a same-cycle write so the registered bit never goes stale
  always_comb begin
    if (wr_en && (wr_addr == rd_addr)) begin
      rd_bit = wr_bit;
    end else begin
      rd_bit = mem_q[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= INIT_WORD[0];
    end else begin
      data_q <= rd_bit;
    end
  end

  // R8: a write lands in the addressed cell
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_bit));

endmodule

// File: rtl/scrom_cascade.sv
module scrom_cascade (
  input  logic ce_act,
  input  logic oe_act,
  input  logic done_q,
  output logic data_en,
  output logic ceo_n
);

  always_comb begin
    data_en = ce_act && oe_act && !done_q;
    ceo_n   = !(ce_act && oe_act && done_q);
  end

endmodule

// File: rtl/scrom_serial.sv
module scrom_serial import scrom_pkg::*; #(
  parameter int          CAP_SEL   = 0,
  parameter int          DEPTH_OVR = 64,
  parameter logic [63:0] INIT_WORD = 64'h9E37_79B9_7F4A_7C15,
  parameter rst_pol_e    RST_POL   = POL_RST_HIGH,
  localparam int         DEPTH     = pick_depth(CAP_SEL, DEPTH_OVR),
  localparam int         AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  output logic          data_out,
  output logic          data_en,
  output logic          ceo_n
);

  logic          rst_meta_q;
  logic          rst_sync_n;
  logic          ce_act;
  logic          oe_act;
  logic          done_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  if (RST_POL == POL_RST_HIGH) begin : g_pol_high
    assign oe_act = !rst_oe;
  end else begin : g_pol_low
    assign oe_act = rst_oe;
  end

  assign ce_act = !ce_n;

  scrom_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (!oe_act),
    .adv_req (ce_act && oe_act),
    .addr_q  (addr_q),
    .addr_d  (addr_d),
    .done_q  (done_q)
  );

  scrom_store #(.DEPTH(DEPTH), .AW(AW), .INIT_WORD(INIT_WORD)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .rd_addr (addr_d),
    .data_q  (data_out)
  );

  scrom_cascade u_casc (
    .ce_act  (ce_act),
    .oe_act  (oe_act),
    .done_q  (done_q),
    .data_en (data_en),
    .ceo_n   (ceo_n)
  );

  // R5: cascade output may only be low when this device has been read out
  a_r5_ceo_needs_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ceo_n |-> done_q);

endmodule

// File: tb/scrom_serial_test.sv
module scrom_serial_test;
  import scrom_pkg::*;

  localparam logic [63:0] WA = 64'h0000_0000_0000_B6C5;
  localparam logic [63:0] WB = 64'h0000_0000_009E_3A71;
  localparam logic [63:0] WC = 64'h0000_0000_0000_4D2F;
  localparam int D1 = 16;
  localparam int D2 = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, ce_n1, rst_pin, wr_en, wr_bit, ce_lo, pin_lo;
  logic [3:0] wr_addr;
  logic       d1, en1, ceo1, d2, en2, ceo2, dl, enl, ceol;
  logic       exp1 [D1];
  int nchk = 0, nfail = 0;

  scrom_serial #(.DEPTH_OVR(D1), .INIT_WORD(WA), .RST_POL(POL_RST_HIGH)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n1), .rst_oe(rst_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .data_out(d1), .data_en(en1), .ceo_n(ceo1));

  scrom_serial #(.DEPTH_OVR(D2), .INIT_WORD(WB), .RST_POL(POL_RST_HIGH)) uut2 (
    .clk(clk), .rst_n(rst_n), .ce_n(ceo1), .rst_oe(rst_pin), .wr_en(1'b0),
    .wr_addr(5'd0), .wr_bit(1'b0), .data_out(d2), .data_en(en2), .ceo_n(ceo2));

  scrom_serial #(.DEPTH_OVR(D1), .INIT_WORD(WC), .RST_POL(POL_RST_LOW)) uut_lo (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_lo), .rst_oe(pin_lo), .wr_en(1'b0),
    .wr_addr(4'd0), .wr_bit(1'b0), .data_out(dl), .data_en(enl), .ceo_n(ceol));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  // pin reset for one edge, then enable; leaves caller 1 ns after the enabling negedge
  task automatic restart1();
    @(negedge clk); rst_pin = 1'b1; ce_n1 = 1'b0;
    @(negedge clk); rst_pin = 1'b0; #1;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; rst_pin = 1'b1; ce_n1 = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_bit = 1'b0;
    ce_lo = 1'b0; pin_lo = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(en1 == 1'b0, "R1 data_en in reset", en1, 0);
    check(ceo1 == 1'b1, "R1 ceo_n in reset", ceo1, 1);
    rst_pin = 1'b0; #1;
    check(en1 == 1'b1 && d1 == WA[0], "R1 bit0 after release", d1, WA[0]);
  endtask

  task automatic t_chain();
    int bad = 0, cont = 0;
    restart1();
    for (int k = 0; k < D1 + D2; k++) begin
      logic e;
      e = (k < D1) ? WA[k] : WB[k - D1];
      if (en1 && en2) cont++;
      if (k < D1) begin
        if (!(en1 && !en2 && d1 == e)) bad++;
      end else begin
        if (!(en2 && !en1 && d2 == e)) bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, "R9 concatenated stream", bad, 0);
    check(cont == 0, "R9 no contention", cont, 0);
    check(!en1 && !en2 && !ceo2, "R9 both exhausted", {en1, en2, ceo2}, 0);
  endtask

  task automatic t_readout();
    int bad = 0;
    restart1();
    for (int k = 0; k < 5; k++) begin
      if (!(en1 && d1 == exp1[k])) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2 first bits", bad, 0);
    ce_n1 = 1'b1; #1;
    check(en1 == 1'b0, "R3 disabled output", en1, 0);
    repeat (3) @(negedge clk);
    ce_n1 = 1'b0; #1;
    check(en1 && d1 == exp1[5], "R3 resume same bit", d1, exp1[5]);
    bad = 0;
    for (int k = 5; k < D1; k++) begin
      if (!(en1 && d1 == exp1[k])) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2 remaining bits", bad, 0);
    #1;
    check(en1 == 1'b0, "R4 released after last bit", en1, 0);
    check(ceo1 == 1'b0, "R5 ceo_n low after read-out", ceo1, 0);
    ce_n1 = 1'b1; #1;
    check(ceo1 == 1'b1, "R5 ceo_n follows ce_n high", ceo1, 1);
    @(negedge clk); ce_n1 = 1'b0; #1;
    check(ceo1 == 1'b0, "R5 ceo_n follows ce_n low", ceo1, 0);
    repeat (5) @(negedge clk);
    check(en1 == 1'b0 && ceo1 == 1'b0, "R4 stays finished", en1, 0);
    rst_pin = 1'b1; #1;
    check(ceo1 == 1'b1 && en1 == 1'b0, "R6 ceo_n high on reset", ceo1, 1);
    @(negedge clk); rst_pin = 1'b0; #1;
    check(ceo1 == 1'b1 && en1 && d1 == exp1[0], "R6 restart at bit0", d1, exp1[0]);
  endtask

  task automatic t_polarity();
    int bad = 0;
    @(negedge clk); pin_lo = 1'b0; ce_lo = 1'b0;
    @(negedge clk);
    check(enl == 1'b0 && ceol == 1'b1, "R7 low level resets", enl, 0);
    pin_lo = 1'b1; #1;
    for (int k = 0; k < 4; k++) begin
      if (!(enl && dl == WC[k])) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R7 high level enables", bad, 0);
    pin_lo = 1'b0; #1;
    check(enl == 1'b0, "R7 low level releases output", enl, 0);
    @(negedge clk); pin_lo = 1'b1; #1;
    check(enl && dl == WC[0], "R7 restart at bit0", dl, WC[0]);
  endtask

  task automatic t_write();
    int bad = 0;
    @(negedge clk); rst_pin = 1'b1; ce_n1 = 1'b1;
    for (int k = 0; k < 3; k++) begin
      int a;
      a = (k == 0) ? 0 : (k == 1) ? 7 : 15;
      wr_en = 1'b1; wr_addr = 4'(a); wr_bit = ~exp1[a]; exp1[a] = ~exp1[a];
      @(negedge clk);
    end
    wr_en = 1'b0;
    restart1();
    for (int k = 0; k < D1; k++) begin
      if (!(en1 && d1 == exp1[k])) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8 written bits read back", bad, 0);
  endtask

  task automatic t_sysreset();
    #1;
    check(ceo1 == 1'b0, "R10 precondition read-out done", ceo1, 0);
    rst_n = 1'b0; #1;
    check(ceo1 == 1'b1, "R10 ceo_n high at once", ceo1, 1);
    check(d1 == WA[0] && en1 == 1'b1, "R10 contents restored", d1, WA[0]);
    @(negedge clk); rst_pin = 1'b1; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_pin = 1'b0; #1;
    check(en1 && d1 == WA[0], "R10 read-out from init bit0", d1, WA[0]);
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < D1; i++) exp1[i] = WA[i];
    t_reset_state();
    t_chain();
    t_readout();
    t_polarity();
    t_write();
    t_sysreset();
    summary();
  end

endmodule